// File: doc/BRIEF.md
# Processor Activity Watchdog with Float Disable and Low-Line Output

This block watches a single activity line driven by a processor and pulls an active-low alarm output when that line shows no transition for a programmable number of clock cycles. The activity line has a companion flag that reports whether the line is actually driven or left floating. Whenever the line floats, or the system reset flag is raised, the timer is held at zero and never expires.

The alarm output is also forced low by a supply-low flag at any time, whether or not the timer has run out. An unused activity line (flag set to floating) therefore turns the output into a plain low-line indicator. Both the activity line and the float flag cross into the clock domain through a synchronizer chain before they are used. The supply-low and system reset flags are taken as already synchronous.

Top module: `wdog_lowline`

## Requirements
- R1: With `sys_rst` low, the float flag clear and no edge on `kick_in`, `wdo_n` falls after exactly `TIMEOUT_CYC` rising clock edges counted from a cleared timer.
- R2: While `sys_rst` is high the timer is held at zero. `wdo_n` is high (if `supply_low` is low) from the first clock edge after `sys_rst` rises.
- R3: While the synchronized float flag is 1, the timer is held at zero and edges on `kick_in` have no effect. The float flag reaches the timer `SYNC_STAGES` edges after `kick_float` changes.
- R4: Counting starts from zero once `sys_rst` is low and the synchronized float flag is 0, with no stimulus needed on `kick_in`.
- R5: `supply_low` = 1 drives `wdo_n` low in the same cycle, without waiting for a clock, regardless of the timer state.
- R6: With `kick_float` held at 1, `wdo_n` follows the inverse of `supply_low`.
- R7: A rising or a falling edge on `kick_in`, including a pulse one clock wide, clears the timer. The edge takes effect on the edge after it leaves the `SYNC_STAGES`-flop synchronizer.
- R8: After expiry, `wdo_n` stays low until an edge, `sys_rst` or a float condition clears the timer.
- R9: While `rst_n` is low, the timer and synchronizers are cleared. `wdo_n` is then high unless `supply_low` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| sys_rst | input | 1 | System reset in progress, active high, synchronous |
| supply_low | input | 1 | Supply below threshold, active high, synchronous |
| kick_in | input | 1 | Processor activity line (asynchronous) |
| kick_float | input | 1 | 1 when the activity line is not driven (asynchronous) |
| wdo_n | output | 1 | Watchdog alarm / low-line output, active low |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is an activity edge and the timer reaching its limit. The bench sends a one-cycle pulse timed so that the timer runs out on the very edge where the synchronized pulse first appears. It then judges that `wdo_n` dips for one cycle and that both edges of the pulse clear the timer afterwards.

The second pair is the supply-low override and a running timer. The bench raises `supply_low` mid-count and expects `wdo_n` low at once, and high again the next cycle with the count undisturbed.

// File: rtl/wdl_pkg.sv
package wdl_pkg;

   // clock cycles in a period given in tenths of a second
   function automatic int unsigned wdl_cycles(input int unsigned clk_hz,
                                              input int unsigned tenths);
      longint unsigned prod;
      prod = longint'(clk_hz) * longint'(tenths) / 10;
      return int'(prod);
   endfunction

endpackage

// File: rtl/wdl_sync.sv
module wdl_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   if (STAGES < 2) begin : g_bad
      $error("wdl_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sr[0] <= RST_VAL;
            else        sr[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sr[i] <= RST_VAL;
            else        sr[i] <= sr[i-1];
      end
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/wdl_edge.sv
module wdl_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic flt,
   output logic act
);
   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;

   // any change counts; a change seen together with float is dropped
   assign act = (lvl ^ lvl_d) & ~flt;

   assert_act_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> (lvl != $past(lvl)));
endmodule

// File: rtl/wdl_timer.sv
module wdl_timer #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic clear,
   output logic expired
);
   localparam int unsigned   CW  = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   if (LIMIT < 2) begin : g_bad
      $error("wdl_timer: LIMIT must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)              cnt <= '0;
      else if (hold || clear)  cnt <= '0;
      else if (cnt != LIM)     cnt <= cnt + 1'b1;

   assign expired = (cnt == LIM);

   assert_hold_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !expired);

   assert_clear_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt == '0));

   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !clear && !expired) |=> (cnt == $past(cnt) + 1'b1));

   assert_expiry_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !hold && !clear) |=> expired);
endmodule

// File: rtl/wdog_lowline.sv
module wdog_lowline #(
   parameter int unsigned CLK_HZ      = 1_000_000,
   parameter int unsigned TIMEOUT_CYC = wdl_pkg::wdl_cycles(CLK_HZ, 16),
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sys_rst,
   input  logic supply_low,
   input  logic kick_in,
   input  logic kick_float,
   output logic wdo_n
);
   logic kick_s;
   logic flt_s;
   logic act;
   logic expired;

   wdl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_kick (
      .clk(clk), .rst_n(rst_n), .d(kick_in), .q(kick_s));

   wdl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_flt (
      .clk(clk), .rst_n(rst_n), .d(kick_float), .q(flt_s));

   wdl_edge u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(kick_s), .flt(flt_s), .act(act));

   wdl_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .hold(sys_rst | flt_s), .clear(act),
      .expired(expired));

   assign wdo_n = ~(expired | supply_low);

   assert_float_lowline_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_s && $past(flt_s) && !supply_low) |-> wdo_n);

   assert_sysrst_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sys_rst) && !supply_low) |-> wdo_n);
endmodule

// File: tb/sim_wdog_lowline.sv
module sim_wdog_lowline;
   localparam int CLK_PERIOD = 10;
   localparam int TMO        = 8;
   localparam int NV         = 34;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sys_rst = 1'b1;
   logic supply_low = 1'b0;
   logic kick_in = 1'b0;
   logic kick_float = 1'b0;
   logic wdo_n;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_lowline #(.CLK_HZ(1000), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .supply_low(supply_low),
      .kick_in(kick_in), .kick_float(kick_float), .wdo_n(wdo_n));

   // {cycles[16:9], req[8:5], sys_rst, supply_low, kick, float, expected wdo_n}
   localparam logic [16:0] VEC [NV] = '{
      {8'd20, 4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R2 held
      {8'd7,  4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R1 one short
      {8'd1,  4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R1 expiry
      {8'd5,  4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R8 sticky
      {8'd2,  4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R8 edge still in sync
      {8'd1,  4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 rising clears
      {8'd7,  4'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
      {8'd1,  4'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      {8'd3,  4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R7 falling clears
      {8'd6,  4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      {8'd1,  4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 one-cycle pulse
      {8'd1,  4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // expiry meets pulse
      {8'd1,  4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      {8'd8,  4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      {8'd1,  4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'd3,  4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
      {8'd1,  4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R5 override mid-count
      {8'd1,  4'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
      {8'd2,  4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R3 float enters
      {8'd30, 4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
      {8'd20, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 edge while floating
      {8'd1,  4'd6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R6 low-line
      {8'd1,  4'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
      {8'd2,  4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 float leaves
      {8'd7,  4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      {8'd1,  4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'd1,  4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R2 clears expiry
      {8'd20, 4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      {8'd7,  4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      {8'd1,  4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'd3,  4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'd1,  4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'd2,  4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // float not yet through
      {8'd1,  4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}
   };

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: wdo_n=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not end");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : stim
      // R9 reset state
      repeat (3) @(negedge clk);
      check("R9", wdo_n, 1'b1);
      supply_low = 1'b1;
      #1 check("R5", wdo_n, 1'b0);
      supply_low = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         sys_rst    = VEC[i][4];
         supply_low = VEC[i][3];
         kick_in    = VEC[i][2];
         kick_float = VEC[i][1];
         for (int c = 0; c < int'(VEC[i][16:9]); c++) @(negedge clk);
         check($sformatf("R%0d vec%0d", VEC[i][8:5], i), wdo_n, VEC[i][0]);
      end

      // R9 asynchronous reset out of expiry
      kick_float = 1'b0;
      repeat (TMO + 4) @(negedge clk);
      check("R1", wdo_n, 1'b0);
      #2 rst_n = 1'b0;
      #1 check("R9", wdo_n, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      // R4: float sync resets to floating, releases after 2 edges
      repeat (2 + TMO - 1) @(negedge clk);
      check("R4", wdo_n, 1'b1);
      @(negedge clk);
      check("R4", wdo_n, 1'b0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule